// File: doc/BRIEF.md
# Armable Debug Register File

This block is the register bank of an on-chip debug unit. A simple byte-wide bus with an address, a write enable, write data and registered read data reaches it. It holds one control byte and four comparator banks of eight bytes each. The control byte carries four fields. An arm flag. A trigger request that is never stored. Four configuration bits. A two-bit bank selector that picks which comparator bank is visible through a shared eight-byte window.

Once the unit is armed, the register map is frozen except for the arm flag, the trigger request and the bank selector. This lets a debugger start a session and know that the comparator setup cannot be disturbed. The lock is decided by the arm value held before each write. Because of this, an arming write may still load the configuration bits, but a disarming write cannot. The block drives the armed state, a one-cycle trigger pulse, the configuration and selector fields, and every comparator byte to the matching logic that sits outside it.

Top module: `dbg_regfile_top`

## Requirements
- R1: After a synchronous reset, all outputs are 0: armed, trigger pulse, configuration, selector, every comparator byte and the read data. The unit starts disarmed with bank 0 selected.
- R2: A read of offset 0x20 returns {arm, 0, cfg[3:0], sel[1:0]}, with bit 7 the arm flag, bits 5:2 the configuration and bits 1:0 the selector. Bit 6 always reads 0.
- R3: A write to 0x20 with bit 6 set makes trig_pulse 1 for exactly the one cycle after the write edge. Any other cycle leaves it 0.
- R4: Writes to 0x20 always load the arm flag from bit 7 and the selector from bits 1:0. While armed, the write does not change bits 5:2.
- R5: A write that clears the arm flag leaves the configuration unchanged. A second write while disarmed changes it.
- R6: The lock uses the arm value held before the write. A write that sets the arm flag from 0 also loads bits 5:2.
- R7: Offsets 0x28+k (k = 0..7) access byte k of the comparator bank chosen by the current selector. The byte order is control, address extension, address high, address low, data high, data low, mask high, mask low.
- R8: While armed, writes to the window are ignored, and the comparator contents stay unchanged.
- R9: Reads of any offset other than 0x20 and 0x28..0x2F return 0. Writes there change nothing.
- R10: cmp_bytes carries bank b byte k at bits [(b*8+k)*8 +: 8].
- R11: Read data is registered. bus_rdata shows the addressed byte in the cycle after the address is presented, using the register state from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write enable for the current address |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| armed | output | 1 | Arm flag |
| trig_pulse | output | 1 | One-cycle trigger strobe |
| cfg | output | 4 | Configuration bits |
| bank_sel | output | 2 | Comparator bank selector |
| cmp_bytes | output | 256 | All comparator bytes, bank-major |

## Verification
The checker relies on three conditions. bus_we is a clean level sampled on each rising edge. Address and data are stable around that edge. Each write occupies one cycle, and consecutive cycles are independent transactions. The bench drives every input on the falling edge and returns bus_we to 0 with the address parked on an unmapped offset after each operation, so a single write never covers two edges. The bench also holds the bus idle during reset, so nothing is attempted while the registers are cleared.

// File: rtl/dbg_regfile_pkg.sv
package dbg_regfile_pkg;
  localparam int CTRL_ARM_BIT  = 7;
  localparam int CTRL_TRIG_BIT = 6;
  localparam int CTRL_CFG_HI   = 5;
  localparam int CTRL_CFG_LO   = 2;
  localparam int CTRL_SEL_HI   = 1;
  localparam int CTRL_SEL_LO   = 0;

  typedef enum logic [2:0] {
    WIN_CTL   = 3'd0,
    WIN_AEXT  = 3'd1,
    WIN_AHI   = 3'd2,
    WIN_ALO   = 3'd3,
    WIN_DHI   = 3'd4,
    WIN_DLO   = 3'd5,
    WIN_MHI   = 3'd6,
    WIN_MLO   = 3'd7
  } win_slot_e;
endpackage

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
  import dbg_regfile_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CFG_W  = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              arm_q,
  output logic              trig_q,
  output logic [CFG_W-1:0]  cfg_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic [DATA_W-1:0] rd_byte
);
  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q  <= 1'b0;
      trig_q <= 1'b0;
      cfg_q  <= '0;
      sel_q  <= '0;
    end else begin
      trig_q <= wr_en & wr_data[CTRL_TRIG_BIT];
      if (wr_en) begin
        arm_q <= wr_data[CTRL_ARM_BIT];
        sel_q <= wr_data[CTRL_SEL_HI:CTRL_SEL_LO];
        // lock uses the flag held before this write
        if (!arm_q) cfg_q <= wr_data[CTRL_CFG_HI:CTRL_CFG_LO];
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    rd_byte[CTRL_ARM_BIT] = arm_q;
    rd_byte[CTRL_CFG_HI:CTRL_CFG_LO] = cfg_q;
    rd_byte[CTRL_SEL_HI:CTRL_SEL_LO] = sel_q;
  end
endmodule

// File: rtl/dbg_cmp_bank.sv
module dbg_cmp_bank #(
  parameter int DATA_W    = 8,
  parameter int WIN_BYTES = 8,
  localparam int OFF_W    = $clog2(WIN_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [OFF_W-1:0]            off,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [DATA_W-1:0]           rd_data,
  output logic [WIN_BYTES*DATA_W-1:0] bytes_flat
);
  logic [DATA_W-1:0] slot_q [WIN_BYTES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WIN_BYTES; i++) slot_q[i] <= '0;
    end else if (wr_en) begin
      slot_q[off] <= wr_data;
    end
  end

  assign rd_data = slot_q[off];

  for (genvar k = 0; k < WIN_BYTES; k++) begin : g_flat
    assign bytes_flat[k*DATA_W +: DATA_W] = slot_q[k];
  end
endmodule

// File: rtl/dbg_read_mux.sv
module dbg_read_mux #(
  parameter int DATA_W  = 8,
  parameter int NUM_CMP = 4,
  localparam int SEL_W  = $clog2(NUM_CMP)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      hit_ctrl,
  input  logic                      hit_win,
  input  logic [SEL_W-1:0]          sel,
  input  logic [DATA_W-1:0]         ctrl_byte,
  input  logic [NUM_CMP*DATA_W-1:0] bank_bytes,
  output logic [DATA_W-1:0]         rdata_q
);
  logic [DATA_W-1:0] next_rd;

  always_comb begin
    next_rd = '0;
    if (hit_ctrl)     next_rd = ctrl_byte;
    else if (hit_win) next_rd = bank_bytes[sel*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= next_rd;
  end
endmodule

// File: rtl/dbg_regfile_top.sv
module dbg_regfile_top #(
  parameter int          DATA_W    = 8,
  parameter int          ADDR_W    = 8,
  parameter int          NUM_CMP   = 4,
  parameter int          WIN_BYTES = 8,
  parameter int          CFG_W     = 4,
  parameter logic [7:0]  CTRL_OFF  = 8'h20,
  parameter logic [7:0]  WIN_OFF   = 8'h28,
  localparam int SEL_W   = $clog2(NUM_CMP),
  localparam int OFF_W   = $clog2(WIN_BYTES),
  localparam int BANK_W  = WIN_BYTES*DATA_W,
  localparam int FLAT_W  = NUM_CMP*BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              armed,
  output logic              trig_pulse,
  output logic [CFG_W-1:0]  cfg,
  output logic [SEL_W-1:0]  bank_sel,
  output logic [FLAT_W-1:0] cmp_bytes
);
  logic                      hit_ctrl, hit_win;
  logic [DATA_W-1:0]         ctrl_byte;
  logic [NUM_CMP*DATA_W-1:0] bank_rd;

  assign hit_ctrl = (bus_addr == CTRL_OFF[ADDR_W-1:0]);
  assign hit_win  = (bus_addr[ADDR_W-1:OFF_W] == WIN_OFF[ADDR_W-1:OFF_W]);

  dbg_ctrl_reg #(.DATA_W(DATA_W), .CFG_W(CFG_W), .SEL_W(SEL_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_we & hit_ctrl),
    .wr_data (bus_wdata),
    .arm_q   (armed),
    .trig_q  (trig_pulse),
    .cfg_q   (cfg),
    .sel_q   (bank_sel),
    .rd_byte (ctrl_byte)
  );

  for (genvar b = 0; b < NUM_CMP; b++) begin : g_bank
    logic bank_we;
    assign bank_we = bus_we & hit_win & ~armed & (bank_sel == SEL_W'(b));
    dbg_cmp_bank #(.DATA_W(DATA_W), .WIN_BYTES(WIN_BYTES)) u_bank (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (bank_we),
      .off        (bus_addr[OFF_W-1:0]),
      .wr_data    (bus_wdata),
      .rd_data    (bank_rd[b*DATA_W +: DATA_W]),
      .bytes_flat (cmp_bytes[b*BANK_W +: BANK_W])
    );
  end

  dbg_read_mux #(.DATA_W(DATA_W), .NUM_CMP(NUM_CMP)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .hit_ctrl   (hit_ctrl),
    .hit_win    (hit_win),
    .sel        (bank_sel),
    .ctrl_byte  (ctrl_byte),
    .bank_bytes (bank_rd),
    .rdata_q    (bus_rdata)
  );
endmodule

// File: rtl/dbg_regfile_chk.sv
module dbg_regfile_chk #(
  parameter int FLAT_W = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [7:0]        bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              armed,
  input logic              trig_pulse,
  input logic [3:0]        cfg,
  input logic [1:0]        bank_sel,
  input logic [FLAT_W-1:0] cmp_bytes
);
  logic ctrl_wr, trig_req, mapped;
  assign ctrl_wr  = bus_we && (bus_addr == 8'h20);
  assign trig_req = ctrl_wr && bus_wdata[6];
  assign mapped   = (bus_addr == 8'h20) || (bus_addr[7:3] == 5'b00101);

  assert_trig_set_R3: assert property (@(posedge clk) disable iff (rst)
    trig_req |=> trig_pulse);
  assert_trig_clear_R3: assert property (@(posedge clk) disable iff (rst)
    !trig_req |=> !trig_pulse);
  assert_arm_sel_load_R4: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (armed == $past(bus_wdata[7])) && (bank_sel == $past(bus_wdata[1:0])));
  assert_cfg_locked_R4: assert property (@(posedge clk) disable iff (rst)
    armed |=> $stable(cfg));
  assert_cmp_locked_R8: assert property (@(posedge clk) disable iff (rst)
    armed |=> $stable(cmp_bytes));
  assert_ctrl_read_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 8'h20) |=> bus_rdata == {$past(armed), 1'b0, $past(cfg), $past(bank_sel)});
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> bus_rdata == 8'h00);
endmodule

bind dbg_regfile_top dbg_regfile_chk #(.FLAT_W(256)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .armed      (armed),
  .trig_pulse (trig_pulse),
  .cfg        (cfg),
  .bank_sel   (bank_sel),
  .cmp_bytes  (cmp_bytes)
);

// File: tb/dbg_regfile_top_test.sv
module dbg_regfile_top_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_we = 1'b0;
  logic [7:0]   bus_addr = 8'h00;
  logic [7:0]   bus_wdata = 8'h00;
  logic [7:0]   bus_rdata;
  logic         armed, trig_pulse;
  logic [3:0]   cfg;
  logic [1:0]   bank_sel;
  logic [255:0] cmp_bytes;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  dbg_regfile_top uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .armed(armed),
    .trig_pulse(trig_pulse), .cfg(cfg), .bank_sel(bank_sel),
    .cmp_bytes(cmp_bytes)
  );

  // {is_write, addr, data, expected read}
  localparam int NV = 26;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h20, 8'h3C, 8'h00},  // R4 cfg=1111 sel=0
    {1'b0, 8'h20, 8'h00, 8'h3C},  // R2
    {1'b1, 8'h28, 8'h11, 8'h00},  // R7 bank0 ctl
    {1'b1, 8'h2F, 8'h88, 8'h00},  // R7 bank0 mask lo
    {1'b0, 8'h28, 8'h00, 8'h11},
    {1'b0, 8'h2F, 8'h00, 8'h88},
    {1'b1, 8'h20, 8'h01, 8'h00},  // sel=1 cfg=0
    {1'b0, 8'h28, 8'h00, 8'h00},  // R7 bank1 empty
    {1'b1, 8'h2A, 8'hA5, 8'h00},
    {1'b0, 8'h2A, 8'h00, 8'hA5},
    {1'b1, 8'h20, 8'h00, 8'h00},  // back to bank0
    {1'b0, 8'h28, 8'h00, 8'h11},
    {1'b0, 8'h2A, 8'h00, 8'h00},
    {1'b1, 8'h20, 8'hD6, 8'h00},  // R6 arm + cfg 0101 + sel 2
    {1'b0, 8'h20, 8'h00, 8'h96},  // R2 bit6 reads 0
    {1'b1, 8'h20, 8'hBD, 8'h00},  // R4 locked cfg, sel 1
    {1'b0, 8'h20, 8'h00, 8'h95},
    {1'b1, 8'h2A, 8'h77, 8'h00},  // R8 ignored
    {1'b0, 8'h2A, 8'h00, 8'hA5},
    {1'b1, 8'h20, 8'h3C, 8'h00},  // R5 disarm, cfg stays
    {1'b0, 8'h20, 8'h00, 8'h14},
    {1'b1, 8'h20, 8'h3C, 8'h00},  // R5 second write
    {1'b0, 8'h20, 8'h00, 8'h3C},
    {1'b1, 8'h30, 8'hFF, 8'h00},  // R9 unmapped write
    {1'b0, 8'h30, 8'h00, 8'h00},
    {1'b0, 8'h27, 8'h00, 8'h00}
  };

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge with bus idle
  task automatic op(logic we, logic [7:0] a, logic [7:0] d);
    bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 armed", armed, 0);
    chk("R1 trig", trig_pulse, 0);
    chk("R1 cfg/sel", {cfg, bank_sel}, 0);
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 cmp_bytes", cmp_bytes, 0);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][24], VEC[i][23:16], VEC[i][15:8]);
      if (!VEC[i][24]) chk("R7/R2/R9/R11 table read", bus_rdata, VEC[i][7:0]);
    end

    // R10 flat layout
    chk("R10 bank0 byte0", cmp_bytes[7:0], 8'h11);
    chk("R10 bank0 byte7", cmp_bytes[63:56], 8'h88);
    chk("R10 bank1 byte2", cmp_bytes[64+16 +: 8], 8'hA5);
    chk("R10 bank1 byte0", cmp_bytes[64 +: 8], 8'h00);

    // R3 trigger pulse
    chk("R3 idle", trig_pulse, 0);
    op(1'b1, 8'h20, 8'h7C);
    chk("R3 pulse high", trig_pulse, 1);
    chk("R4 cfg loaded", cfg, 4'hF);
    op(1'b0, 8'h00, 8'h00);
    chk("R3 pulse low", trig_pulse, 0);
    op(1'b1, 8'h28, 8'h40);
    chk("R3 window bit6 no pulse", trig_pulse, 0);

    // R4 arm and selector load while armed
    op(1'b1, 8'h20, 8'h80);
    chk("R6 arm cfg load", {armed, cfg, bank_sel}, {1'b1, 4'h0, 2'd0});
    op(1'b1, 8'h20, 8'hBF);
    chk("R4 armed sel write", {armed, cfg, bank_sel}, {1'b1, 4'h0, 2'd3});
    op(1'b1, 8'h2B, 8'h5A);
    chk("R8 bank3 unchanged", cmp_bytes[192 +: 64], 64'h0);
    op(1'b1, 8'h20, 8'h03);
    chk("R5 disarm keeps cfg", {armed, cfg, bank_sel}, {1'b0, 4'h0, 2'd3});
    op(1'b1, 8'h2B, 8'h5A);
    chk("R7 bank3 addr lo", cmp_bytes[192+24 +: 8], 8'h5A);

    // R11 read reflects state before the edge
    bus_we = 1'b1; bus_addr = 8'h20; bus_wdata = 8'h08;
    @(negedge clk);
    chk("R11 read shows pre-write", bus_rdata, 8'h03);
    bus_we = 1'b0;
    @(negedge clk);
    chk("R11 read shows new", bus_rdata, 8'h08);

    // R1 reset again mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 re-reset cmp", cmp_bytes, 0);
    chk("R1 re-reset ctrl", {armed, trig_pulse, cfg, bank_sel, bus_rdata}, 0);

    done = 1;
    finish_run();
  end
endmodule